// File: doc/BRIEF.md
# Flash Read-Data Sampler

This block sits between the four data pads of a quad-lane serial flash and the read path of a flash controller. Read data returns from the flash after a board- and device-dependent delay, so the point at which it is stable moves relative to the internal serial clock. The sampler lets software pick that point at run time. It can register the nibble on the rising or the falling edge of the clock. It then passes the nibble through a short or a long delay pipeline, and presents it to the controller as an aligned nibble with a one-cycle valid strobe.

An 8-bit configuration register holds two independent settings. One covers commands that run at the full serial rate. The other covers commands that run at half rate, where every bit period spans two clocks. An enable bit in the same register picks which of the two settings is active. The register accepts a write only while the sampler is idle, so a transfer never runs with a mixture of old and new settings. The serial clock is `clk` itself. Chip select `cs_n` is low for the whole read phase of a command.

Top module: `flash_rx_sampler`

## Requirements
- R1: A synchronous active-low reset clears the configuration register to 0x00 and holds `rx_valid` low. A write presented during reset is ignored. The value 0x00 selects rising-edge capture, short delay and full speed.
- R2: Register decode. Bit 0 enables half speed. Bits 1 and 2 are the half-speed phase and delay. Bits 5 and 6 are the full-speed phase and delay. Phase 1 means capture on the falling edge. Delay 1 means the long delay. Bits 3, 4 and 7 are stored and read back on `cfg_rdata` but have no effect. When bit 0 is 1, bits 5 and 6 have no effect. When bit 0 is 0, bits 1 and 2 have no effect. An accepted write is visible on `cfg_rdata` after the clock edge that takes it.
- R3: A write is accepted only when `cs_n` is high and no captured sample is still inside the sampler. A write made while `cs_n` is low leaves the register unchanged.
- R4: With rising-edge capture at full speed, `sdi` is registered on each rising edge at which `cs_n` is low. With the short delay, that nibble appears on `rx_data`, with `rx_valid` high, in the cycle after the next rising edge, one clock after capture.
- R5: With falling-edge capture, `sdi` is registered on each falling edge at which `cs_n` is low. The nibble appears after the first rising edge that follows the falling edge (short delay) or after the second (long delay).
- R6: At full speed, the long delay adds exactly one clock of latency to the short-delay timing, for either capture edge.
- R7: At half speed, bit periods are two clocks long and start at the first rising edge at which `cs_n` is low. One sample is taken per period. Rising-edge capture uses the first rising edge of the period. Falling-edge capture uses the falling edge in the middle of the period. Each delay stage spans two clocks, so the latency is 2 (short) or 4 (long) rising edges after the rising-edge capture timing of R4.
- R8: `rx_valid` is a one-cycle pulse per sample and is raised only for samples taken while `cs_n` is low. Changes on `sdi` while `cs_n` is high produce no pulse. At half speed, `rx_valid` is never high in two consecutive cycles.
- R9: At full speed, while `cs_n` is held low, one pulse is produced every clock, and the nibbles come out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal serial clock; all outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Current configuration register value |
| cs_n | input | 1 | Chip select, low while read data is arriving |
| sdi | input | LANES (4) | Read data from the flash lanes |
| rx_data | output | LANES (4) | Aligned sampled nibble |
| rx_valid | output | 1 | One-cycle strobe marking a new nibble on rx_data |

## Verification
The assertions assume that `sdi` and `cs_n` change away from both clock edges. They also assume that a low period of `cs_n` covers whole bit periods, and that the configuration does not change while samples move through the pipeline, which the idle gate on writes enforces. The stimulus drives every input one nanosecond after a rising edge. It holds each nibble for one clock at full speed and for two clocks at half speed. After each burst it waits ten clocks before the next write, so a new setting never meets a sample still in flight. Writes made during a burst deliberately test the rejection path. Random `sdi` values keep toggling while `cs_n` is high to confirm that no pulse escapes.

// File: rtl/frs_pkg.sv
// Package: shared decode for the flash read-data sampler.
// Holds the configuration field positions and the function that turns
// a raw register value into the active sampling selection.
package frs_pkg;

    localparam int CFG_W      = 8;
    localparam int BIT_HS_EN  = 0;
    localparam int BIT_HS_PH  = 1;
    localparam int BIT_HS_DLY = 2;
    localparam int BIT_FS_PH  = 5;
    localparam int BIT_FS_DLY = 6;

    // Active sampling choice after the half-speed enable has picked a field pair.
    typedef struct packed {
        logic invert;    // 1: capture on the falling edge
        logic long_dly;  // 1: two delay stages
        logic half;      // 1: half-rate bit periods
    } samp_sel_t;

    // Select the full- or half-speed pair of fields from the register.
    function automatic samp_sel_t decode_cfg(input logic [CFG_W-1:0] c);
        samp_sel_t s;
        s.half     = c[BIT_HS_EN];
        s.invert   = c[BIT_HS_EN] ? c[BIT_HS_PH]  : c[BIT_FS_PH];
        s.long_dly = c[BIT_HS_EN] ? c[BIT_HS_DLY] : c[BIT_FS_DLY];
        return s;
    endfunction

endpackage

// File: rtl/frs_cfg_reg.sv
// Module: configuration register of the sampler.
// Accepts a write only when chip select is high and nothing is in flight,
// then presents the decoded selection. Assumes busy covers every stage.
module frs_cfg_reg
    import frs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cs_n,
    input  logic             busy,
    output logic [CFG_W-1:0] cfg_q,
    output samp_sel_t        sel
);

    logic idle;

    // Idle means no transfer and no sample anywhere in the path.
    assign idle = cs_n && !busy;

    // Register update, gated by the idle condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we && idle) begin
            cfg_q <= cfg_wdata;
        end
    end

    // Field selection for the active command rate.
    always_comb begin
        sel = decode_cfg(cfg_q);
    end

    // R3: a write during a transfer leaves the register untouched
    p_wr_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cs_n) |=> $stable(cfg_q));

    // R3: a write while samples are still in flight is rejected
    p_wr_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && busy) |=> $stable(cfg_q));

    // R2: an accepted write is read back on the next cycle
    p_wr_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cs_n && !busy) |=> (cfg_q == $past(cfg_wdata)));

endmodule

// File: rtl/frs_capture.sv
// Module: edge capture stage.
// Registers the lanes on both clock edges and tags each sample as
// usable when chip select is low and, at half rate, when the bit-period
// counter points at the chosen position. Assumes HS_RATIO >= 2.
module frs_capture #(
    parameter int LANES    = 4,
    parameter int HS_RATIO = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             half,
    input  logic [LANES-1:0] sdi,
    output logic [LANES-1:0] r_data,
    output logic             r_vld,
    output logic [LANES-1:0] f_data,
    output logic             f_vld
);

    localparam int CNT_W = (HS_RATIO > 1) ? $clog2(HS_RATIO) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HS_RATIO - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(1);

    logic [CNT_W-1:0] hs_cnt;
    logic             rise_take;
    logic             fall_take;

    // Position within the half-rate bit period, restarted by chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_cnt <= '0;
        end else if (cs_n) begin
            hs_cnt <= '0;
        end else begin
            hs_cnt <= (hs_cnt == CNT_LAST) ? '0 : hs_cnt + CNT_W'(1);
        end
    end

    // Which edges of the period carry a usable sample.
    assign rise_take = !half || (hs_cnt == '0);
    assign fall_take = !half || (hs_cnt == CNT_MID);

    // Rising-edge capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_data <= '0;
            r_vld  <= 1'b0;
        end else begin
            r_data <= sdi;
            r_vld  <= !cs_n && rise_take;
        end
    end

    // Falling-edge capture register, read by the rising domain half a cycle later.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            f_data <= '0;
            f_vld  <= 1'b0;
        end else begin
            f_data <= sdi;
            f_vld  <= !cs_n && fall_take;
        end
    end

    // R8: no rising-edge sample is tagged for a cycle with chip select high
    p_no_idle_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !r_vld);

    // R7: at half rate the rising path tags at most one edge in two
    p_half_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (half && r_vld) |=> !r_vld);

endmodule

// File: rtl/frs_delay_pipe.sv
// Module: delay pipeline with selectable tap.
// Picks the rising or falling capture, shifts it through DEPTH stages
// and taps the stage given by the delay and rate setting. Assumes the
// selection is stable while any stage holds a sample.
module frs_delay_pipe
    import frs_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int HS_RATIO  = 2,
    parameter int SHORT_DLY = 1,
    parameter int LONG_DLY  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  samp_sel_t        sel,
    input  logic [LANES-1:0] r_data,
    input  logic             r_vld,
    input  logic [LANES-1:0] f_data,
    input  logic             f_vld,
    output logic [LANES-1:0] out_data,
    output logic             out_vld,
    output logic             busy
);

    localparam int DEPTH = LONG_DLY * HS_RATIO;
    localparam int TAP_W = $clog2(DEPTH + 1);

    logic [LANES-1:0] in_data;
    logic             in_vld;
    logic [DEPTH:1]   st_vld;
    logic [LANES-1:0] st_data [1:DEPTH];
    logic [TAP_W-1:0] tap;

    // Capture edge selection feeding the first stage.
    assign in_vld  = sel.invert ? f_vld  : r_vld;
    assign in_data = sel.invert ? f_data : r_data;

    // Stage index that drives the outputs.
    always_comb begin
        tap = TAP_W'((sel.long_dly ? LONG_DLY : SHORT_DLY) * (sel.half ? HS_RATIO : 1));
    end

    for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
        logic             vld_src;
        logic [LANES-1:0] dat_src;
        logic             vld_q;
        logic [LANES-1:0] dat_q;

        if (k == 1) begin : g_head
            assign vld_src = in_vld;
            assign dat_src = in_data;
        end else begin : g_tail
            assign vld_src = st_vld[k-1];
            assign dat_src = st_data[k-1];
        end

        // One clock of delay per stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                dat_q <= '0;
            end else begin
                vld_q <= vld_src;
                dat_q <= dat_src;
            end
        end

        assign st_vld[k]  = vld_q;
        assign st_data[k] = dat_q;
    end

    // Output tap selection.
    always_comb begin
        out_vld  = 1'b0;
        out_data = '0;
        for (int k = 1; k <= DEPTH; k++) begin
            if (tap == TAP_W'(k)) begin
                out_vld  = st_vld[k];
                out_data = st_data[k];
            end
        end
    end

    // Anything captured or still shifting blocks configuration writes.
    assign busy = (|st_vld) || r_vld || f_vld;

    // R4: a short full-rate sample reaches the output one clock later
    p_lat_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && tap == TAP_W'(1)) |=> out_vld);

    // R6: a two-stage setting reaches the output two clocks later
    p_lat_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && tap == TAP_W'(2)) |-> ##2 out_vld);

    // R8: half-rate strobes are never back to back
    p_half_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.half && out_vld) |=> !out_vld);

endmodule

// File: rtl/flash_rx_sampler.sv
// Module: top of the flash read-data sampler.
// Wires the configuration register, the edge capture stage and the delay
// pipeline. Assumes clk is the serial clock and inputs settle between edges.
module flash_rx_sampler
    import frs_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int HS_RATIO  = 2,
    parameter int SHORT_DLY = 1,
    parameter int LONG_DLY  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             cs_n,
    input  logic [LANES-1:0] sdi,
    output logic [LANES-1:0] rx_data,
    output logic             rx_valid
);

    samp_sel_t        sel;
    logic             busy;
    logic [LANES-1:0] r_data;
    logic             r_vld;
    logic [LANES-1:0] f_data;
    logic             f_vld;

    frs_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cs_n      (cs_n),
        .busy      (busy),
        .cfg_q     (cfg_rdata),
        .sel       (sel)
    );

    frs_capture #(
        .LANES    (LANES),
        .HS_RATIO (HS_RATIO)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .half   (sel.half),
        .sdi    (sdi),
        .r_data (r_data),
        .r_vld  (r_vld),
        .f_data (f_data),
        .f_vld  (f_vld)
    );

    frs_delay_pipe #(
        .LANES     (LANES),
        .HS_RATIO  (HS_RATIO),
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .r_data   (r_data),
        .r_vld    (r_vld),
        .f_data   (f_data),
        .f_vld    (f_vld),
        .out_data (rx_data),
        .out_vld  (rx_valid),
        .busy     (busy)
    );

endmodule

// File: tb/flash_rx_sampler_bench.sv
// Bench: behavioural reference model (event queue keyed by due cycle)
// compared with the sampler after every rising edge.
module flash_rx_sampler_bench;

    localparam int LANES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [7:0]       cfg_wdata = 8'h00;
    logic             cs_n = 1'b1;
    logic [LANES-1:0] sdi = '0;
    logic [7:0]       cfg_rdata;
    logic [LANES-1:0] rx_data;
    logic             rx_valid;

    flash_rx_sampler u_flash_rx_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    always #2 clk = ~clk;   // 250 MHz

    int    checks = 0;
    int    errors = 0;
    int    edges  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    typedef struct {
        int               due;
        logic [LANES-1:0] d;
    } ev_t;

    ev_t              q[$];
    int               cyc = 0;
    logic [7:0]       m_cfg = 8'h00;
    int               m_hs = 0;
    logic             exp_v;
    logic [LANES-1:0] exp_d;

    // Model view of the active setting, from the requirement decode.
    function automatic bit m_half(input logic [7:0] c);
        return c[0];
    endfunction
    function automatic bit m_inv(input logic [7:0] c);
        return c[0] ? c[1] : c[5];
    endfunction
    function automatic int m_lat(input logic [7:0] c);
        int base;
        base = (c[0] ? c[2] : c[6]) ? 2 : 1;
        return c[0] ? base * 2 : base;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model, rising edge: capture, register write, period counter.
    always @(posedge clk) begin
        edges++;
        if (!rst_n) begin
            cyc   = 0;
            m_cfg = 8'h00;
            m_hs  = 0;
            q.delete();
        end else begin
            cyc++;
            if (!cs_n && !m_inv(m_cfg) && (!m_half(m_cfg) || m_hs == 0))
                q.push_back('{cyc + m_lat(m_cfg), sdi});
            if (cfg_we && cs_n) m_cfg = cfg_wdata;
            m_hs = cs_n ? 0 : (m_hs ^ 1);
        end
    end

    // Reference model, falling edge capture.
    always @(negedge clk) begin
        if (rst_n && !cs_n && m_inv(m_cfg) && (!m_half(m_cfg) || m_hs == 1))
            q.push_back('{cyc + m_lat(m_cfg), sdi});
    end

    // Compare outputs with the model three quarters into each cycle.
    always @(negedge clk) begin
        #1;
        if (edges > 0 && !done) begin
            exp_v = 1'b0;
            exp_d = '0;
            while (q.size() > 0 && q[0].due <= cyc) begin
                if (q[0].due == cyc) begin
                    exp_v = 1'b1;
                    exp_d = q[0].d;
                end
                void'(q.pop_front());
            end
            chk(cur_req, "rx_valid", 32'(rx_valid), 32'(exp_v));
            if (exp_v) chk(cur_req, "rx_data", 32'(rx_data), 32'(exp_d));
            chk(cur_req, "cfg_rdata", 32'(cfg_rdata), 32'(m_cfg));
        end
    end

    task automatic write_cfg(input logic [7:0] v, input string req);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        chk(req, "readback after write", 32'(cfg_rdata), 32'(v));
    endtask

    // One read burst: program, hold cs_n low for nbits periods, then idle.
    task automatic burst(input logic [7:0] cfgv, input string req,
                         input int nbits, input bit mid_wr);
        int per;
        cur_req = req;
        write_cfg(cfgv, req);
        repeat (2) begin @(posedge clk); #1; end
        per = cfgv[0] ? 2 : 1;
        cs_n = 1'b0;
        for (int b = 0; b < nbits; b++) begin
            sdi = LANES'($urandom);
            for (int p = 0; p < per; p++) begin
                if (mid_wr && b == nbits / 2 && p == 0) begin
                    cfg_we = 1'b1;
                    cfg_wdata = ~cfgv;
                end else begin
                    cfg_we = 1'b0;
                end
                @(posedge clk); #1;
            end
        end
        cfg_we = 1'b0;
        cs_n = 1'b1;
        if (mid_wr) chk("R3", "register after write during transfer", 32'(cfg_rdata), 32'(cfgv));
        // R8: idle lane activity must not produce strobes
        repeat (10) begin
            sdi = LANES'($urandom);
            @(posedge clk); #1;
        end
    endtask

    initial begin
        cfg_we = 1'b1;          // R1: write during reset must be ignored
        cfg_wdata = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cfg_we = 1'b0;
        @(posedge clk); #1;
        chk("R1", "cfg after reset", 32'(cfg_rdata), 32'h00);
        chk("R1", "rx_valid after reset", 32'(rx_valid), 32'h0);

        burst(8'h00, "R4", 12, 1'b0);
        burst(8'h20, "R5", 12, 1'b0);
        burst(8'h40, "R6", 12, 1'b0);
        burst(8'h60, "R6", 12, 1'b0);
        burst(8'h98, "R2", 10, 1'b0);
        burst(8'hB8, "R2", 10, 1'b0);
        burst(8'h00, "R9", 20, 1'b0);
        burst(8'h20, "R3", 10, 1'b1);
        burst(8'h01, "R7", 8, 1'b0);
        burst(8'h03, "R7", 8, 1'b0);
        burst(8'h05, "R7", 8, 1'b0);
        burst(8'h07, "R8", 8, 1'b1);
        burst(8'h61, "R2", 8, 1'b0);
        burst(8'h06, "R2", 10, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule